// File: doc/BRIEF.md
# Sample-Strobed Numerically Controlled Oscillator

This block produces an audio tone by phase accumulation. A phase register holds a fraction of one waveform cycle. Each time the audio sample strobe pulses (nominally once every 10 microseconds, at 100 kHz), the register grows by a phase step that the host has written. A full cycle completes when the register rolls past its largest value. The host works out the step as tone frequency divided by sample rate, scaled to the register width. For example, 16.35 Hz at 100 kHz is about 0.0001635 of a cycle per sample. The block knows nothing of notes or frequencies. It adds only the step it is given.

There are two outputs. The top phase bit is a square wave that can drive a pin directly. The upper bits of the phase form an address for a downstream waveform table. The phase register must be at least 24 bits wide, so that even the lowest notes keep sub-percent phase resolution. A synchronous reset clears both the phase and the step, which leaves the output silent. An optional output register stage, selected by a parameter, retimes both outputs.

Top module: `nco_tone`

## Requirements
- R1: While `rst` is high at a clock edge, the phase and the step are cleared. After reset, `tone_o` is 0 and `tab_addr_o` is 0, and they stay 0 through any number of sample strobes until a step is written.
- R2: The phase changes only on clock edges where `smp_stb` is high. On all other cycles, `tone_o` and `tab_addr_o` hold their values.
- R3: On each strobe the phase becomes (phase + step) modulo 2^PHASE_W. It wraps with no saturation, so a step of 2^(PHASE_W-1) returns to the starting phase after two strobes, and an all-ones step moves the phase back by one LSB.
- R4: `tone_o` equals bit PHASE_W-1 of the phase (the MSB).
- R5: `tab_addr_o` equals phase bits [PHASE_W-1 : PHASE_W-ADDR_W], with the MSB of the phase as the MSB of the address.
- R6: A step written with `inc_we` is used by strobes in later cycles. A strobe in the same cycle as a write still adds the old step.
- R7: Writing a new step never changes the accumulated phase.
- R8: With OUT_REG=1, a strobe sampled at clock edge k shows up on both outputs after edge k+1.
- R9: PHASE_W is at least 24 and ADDR_W is between 1 and PHASE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle audio sample strobe |
| inc_we | input | 1 | Write enable for the phase step register |
| inc_wdata | input | PHASE_W | Phase step, an unsigned fraction of one cycle |
| tone_o | output | 1 | Square-wave tone (phase MSB) |
| tab_addr_o | output | ADDR_W | Waveform table address (upper phase bits) |

## Verification
The main function is driven with a range of step patterns, each checked against a model of the phase:
- a low-note step, which shows that small fractions carry into the address bits;
- a mid-range step, which shows repeated rollover through the MSB;
- a half-cycle step, which toggles the tone on every strobe;
- an all-ones step, which must move the phase backwards by one LSB and so separates modulo wrap from saturation;
- a zero step, which must hold the phase.

Directed cases then cover these points:
- long idle gaps with no strobe;
- a write in the same cycle as a strobe, which separates the old step from the new one;
- a write that must leave the phase intact;
- strobes straight after reset, which show the cleared step;
- a reset in the middle of a run.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_DEF_PHASE_W = 32;
  localparam int unsigned NCO_DEF_ADDR_W  = 10;
  localparam int unsigned NCO_MIN_PHASE_W = 24;
endpackage

// File: rtl/nco_step_reg.sv
module nco_step_reg #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PHASE_W-1:0] wdata,
  output logic [PHASE_W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (rst)     step_q <= '0;
    else if (we) step_q <= wdata;
  end

  AST_STEP_CLEAR: assert property (@(posedge clk) rst |=> step_q == '0); // R1
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(step_q)); // R6
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase_q
);
  logic [PHASE_W-1:0] phase_nxt;

  always_comb begin
    phase_nxt = phase_q;
    if (stb) phase_nxt = phase_q + step;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nxt;
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) rst |=> phase_q == '0); // R1
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(phase_q)); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (stb && step == '1) |=> phase_q == $past(phase_q) - 1'b1); // R3
endmodule

// File: rtl/nco_tap.sv
module nco_tap #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               tone_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned LSB = PHASE_W - ADDR_W;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          tone_o <= 1'b0;
          addr_o <= '0;
        end else begin
          tone_o <= phase_i[PHASE_W-1];
          addr_o <= phase_i[PHASE_W-1:LSB];
        end
      end

      AST_TONE_MSB: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tone_o == $past(phase_i[PHASE_W-1])); // R4
      AST_ADDR_TOP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> addr_o[ADDR_W-1] == tone_o); // R5
    end else begin : g_comb
      assign tone_o = phase_i[PHASE_W-1];
      assign addr_o = phase_i[PHASE_W-1:LSB];
    end
  endgenerate
endmodule

// File: rtl/nco_tone.sv
module nco_tone
  import nco_pkg::*;
#(
  parameter int unsigned PHASE_W = NCO_DEF_PHASE_W,
  parameter int unsigned ADDR_W  = NCO_DEF_ADDR_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_stb,
  input  logic               inc_we,
  input  logic [PHASE_W-1:0] inc_wdata,
  output logic               tone_o,
  output logic [ADDR_W-1:0]  tab_addr_o
);
  logic [PHASE_W-1:0] step_q;
  logic [PHASE_W-1:0] phase_q;

  initial begin
    AST_PARAM_RANGE: assert (PHASE_W >= NCO_MIN_PHASE_W && ADDR_W >= 1
                             && ADDR_W <= PHASE_W); // R9
  end

  nco_step_reg #(.PHASE_W(PHASE_W)) u_step (
    .clk(clk), .rst(rst), .we(inc_we), .wdata(inc_wdata), .step_q(step_q)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .stb(smp_stb), .step(step_q), .phase_q(phase_q)
  );

  nco_tap #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_tap (
    .clk(clk), .rst(rst), .phase_i(phase_q), .tone_o(tone_o), .addr_o(tab_addr_o)
  );

  AST_WRITE_KEEPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (inc_we && !smp_stb) |=> $stable(phase_q)); // R7
endmodule

// File: tb/nco_tone_bench.sv
module nco_tone_bench;
  localparam int unsigned PW = 32;
  localparam int unsigned AW = 10;

  typedef struct packed {
    logic [PW-1:0] step;
    logic [7:0]    n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{step: 32'h000A_B717, n: 8'd40},
    '{step: 32'h0123_4567, n: 8'd60},
    '{step: 32'h8000_0000, n: 8'd6},
    '{step: 32'hFFFF_FFFF, n: 8'd5},
    '{step: 32'h0000_0000, n: 8'd4},
    '{step: 32'h3FFF_FFFF, n: 8'd12}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic inc_we = 1'b0;
  logic [PW-1:0] inc_wdata = '0;
  logic tone_o;
  logic [AW-1:0] tab_addr_o;

  int checks = 0;
  int errors = 0;
  logic [PW-1:0] ph_m = '0;
  logic [PW-1:0] st_m = '0;

  always #2.5 clk = ~clk;

  nco_tone #(.PHASE_W(PW), .ADDR_W(AW), .OUT_REG(1'b1)) u_nco_tone (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .inc_we(inc_we),
    .inc_wdata(inc_wdata), .tone_o(tone_o), .tab_addr_o(tab_addr_o)
  );

  task automatic check_out(input string req);
    checks++;
    if (tone_o !== ph_m[PW-1]) begin
      errors++;
      $display("FAIL %s tone actual %0b expected %0b", req, tone_o, ph_m[PW-1]);
    end
    checks++;
    if (tab_addr_o !== ph_m[PW-1 -: AW]) begin
      errors++;
      $display("FAIL %s addr actual %0h expected %0h", req, tab_addr_o, ph_m[PW-1 -: AW]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // strobe one cycle, then wait for the output register (R8)
  task automatic strobe();
    smp_stb = 1'b1;
    tick();
    smp_stb = 1'b0;
    ph_m = ph_m + st_m;
    tick();
  endtask

  task automatic write_step(input logic [PW-1:0] v);
    inc_we = 1'b1;
    inc_wdata = v;
    tick();
    inc_we = 1'b0;
    st_m = v;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check_out("R1 reset");
    for (int i = 0; i < 5; i++) strobe();
    check_out("R1 zero step after reset");

    for (int v = 0; v < 6; v++) begin
      write_step(VEC[v].step);
      check_out("R7 write keeps phase");
      for (int s = 0; s < int'(VEC[v].n); s++) begin
        strobe();
        check_out("R3 R4 R5 R8 accumulate");
      end
    end

    // R2: idle cycles hold the outputs
    write_step(32'h0567_89AB);
    strobe();
    repeat (50) tick();
    check_out("R2 idle hold");

    // R3: half-cycle step returns to start after two strobes
    write_step(32'h8000_0000);
    strobe();
    check_out("R3 half");
    strobe();
    check_out("R3 half wrap");

    // R6: write in same cycle as strobe uses old step
    write_step(32'h0100_0000);
    smp_stb = 1'b1;
    inc_we = 1'b1;
    inc_wdata = 32'h2000_0000;
    tick();
    smp_stb = 1'b0;
    inc_we = 1'b0;
    ph_m = ph_m + st_m;
    st_m = 32'h2000_0000;
    tick();
    check_out("R6 same-cycle old step");
    strobe();
    check_out("R6 new step");

    // R1: reset mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    ph_m = '0;
    st_m = '0;
    tick();
    check_out("R1 mid-run reset");
    strobe();
    strobe();
    check_out("R1 step cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule